// File: doc/BRIEF.md
# Timestamping Input Event Unit

This block watches general-purpose input pins against a free-running local time count. It recognises an event on one pin, either a single edge or a complete pulse, and records the time at which the event happened. A stage watches one pin chosen by a select field. Its active polarity is programmable. In pulse mode it accepts a pulse only when the pulse width, counted in clock cycles, lies inside a programmed window.

Several detector stages can be chained. Stage zero arms first. Each later stage arms only after the stage before it has fired, and the recorded event is raised only when the last programmed stage fires. If an armed later stage does not fire within a programmed number of cycles, the chain falls back to stage zero. This lets a compound pattern of edges and pulses spread over several pins produce one timestamp.

Timestamps go into an eight-entry queue. The host reads the queue through a show-ahead port at its own pace, independently of when events occur. An event that finds the queue full is dropped, and a sticky overflow flag records the loss. Each pin passes through a two-flop synchronizer. The recorded time is corrected by those two cycles, so it equals the count value in the cycle where the pin changed.

Top module: `evt_capture_unit`

## Requirements
- R1: After reset the queue is empty (`rd_valid` low), `ovf_flag` is low and the chain waits in stage zero.
- R2: A stage in edge mode (`cfg_mode` bit 0) fires on a rising edge of its pin when its `cfg_pol` bit is 1 and on a falling edge when it is 0. The opposite edge is ignored.
- R3: The queued timestamp equals the `time_in` value during the clock cycle in which the pin changed between two rising clock edges. The entry becomes visible on `rd_valid`/`rd_data` after the third rising edge following the change.
- R4: A stage in pulse mode (`cfg_mode` bit 1) fires at the trailing edge of a pulse at the active level given by `cfg_pol`. It fires only when the pulse lasted W clock cycles with `cfg_wmin` ≤ W ≤ `cfg_wmax`, and it stamps the trailing edge.
- R5: Stage k watches `pins_in[cfg_sel[2k+1:2k]]`. Activity on the other pins has no effect on it.
- R6: The queue is first-in first-out and holds 8 entries. `rd_data` shows the oldest entry while `rd_valid` is high, and a one-cycle `rd_pop` removes it. A pop on an empty queue changes nothing.
- R7: An event that finds the queue full with no pop in the same cycle is dropped and sets `ovf_flag`. The flag stays set until a cycle with `ovf_clr` high.
- R8: With `cfg_last` = 1, an event is queued only when stage 0 fires and stage 1 fires afterwards. Its timestamp is that of the stage 1 event. Stage 1 activity while stage 0 has not fired queues nothing. With `cfg_last` = 0, stage 0 alone queues every event.
- R9: Once stage 0 has fired, the chain returns to stage 0 if stage 1 does not fire within `cfg_timeout` cycles. A later stage 1 event then queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_in | input | 32 | Free-running local time count |
| pins_in | input | 4 | Asynchronous input pins |
| cfg_sel | input | 4 | Pin select, 2 bits per stage |
| cfg_mode | input | 2 | Per stage: 0 edge, 1 pulse |
| cfg_pol | input | 2 | Per stage: 1 rising/high-active, 0 falling/low-active |
| cfg_wmin | input | 16 | Minimum pulse width, 8 bits per stage |
| cfg_wmax | input | 16 | Maximum pulse width, 8 bits per stage |
| cfg_last | input | 1 | Index of the final stage of the chain |
| cfg_timeout | input | 16 | Cycles an armed later stage may wait |
| rd_pop | input | 1 | Remove the oldest queued timestamp |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | 32 | Oldest queued timestamp |
| rd_valid | output | 1 | Queue holds at least one entry |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The assertions assume that the configuration inputs stay constant while a pulse or a chain is in progress. They also assume that `ovf_clr` and `rd_pop` are single-cycle host strobes. The stimulus changes configuration only while every pin is idle and the queue has been drained. It drives pins and strobes half a cycle away from the sampling edge, and it keeps random bursts below the queue depth unless an overflow is intended. Pulses are separated by low gaps long enough for each trailing edge to settle before the next leading edge.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic {
    DET_EDGE  = 1'b0,
    DET_PULSE = 1'b1
  } det_mode_e;
endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_in,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] lvl_d
);
  logic [NPINS-1:0] meta_q, lvl_q, lvl_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      lvl_q   <= '0;
      lvl_d_q <= '0;
    end else begin
      meta_q  <= pins_in;
      lvl_q   <= meta_q;
      lvl_d_q <= lvl_q;
    end
  end

  assign lvl   = lvl_q;
  assign lvl_d = lvl_d_q;
endmodule

// File: rtl/evt_stage_det.sv
module evt_stage_det
  import evt_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int WID_W = 8,
  localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] lvl_d,
  input  logic [SEL_W-1:0] sel,
  input  det_mode_e        mode,
  input  logic             pol,
  input  logic [WID_W-1:0] wmin,
  input  logic [WID_W-1:0] wmax,
  output logic             hit
);
  logic             act_now, act_prev, lead, trail, in_win;
  logic [WID_W-1:0] wcnt_q, wcnt_n;

  always_comb begin
    act_now  = pol ? lvl[sel]   : ~lvl[sel];
    act_prev = pol ? lvl_d[sel] : ~lvl_d[sel];
    lead     = act_now & ~act_prev;
    trail    = ~act_now & act_prev;
    wcnt_n   = wcnt_q;
    if (lead) begin
      wcnt_n = WID_W'(1);
    end else if (act_now && (wcnt_q != {WID_W{1'b1}})) begin
      wcnt_n = wcnt_q + WID_W'(1);
    end
    in_win = (wcnt_q >= wmin) && (wcnt_q <= wmax);
    hit    = (mode == DET_EDGE) ? lead : (trail & in_win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_n;
  end

  // R2 / R4: a stage only fires where the synchronized pin changed level
  assert_hit_on_transition_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (lvl[sel] != lvl_d[sel]));
endmodule

// File: rtl/evt_ts_fifo.sv
module evt_ts_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         ovf_clr,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovf_q, ovf_n;
  logic          full, empty, pop_ok, push_ok;

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    empty   = (cnt_q == '0);
    pop_ok  = pop & ~empty;
    push_ok = push & (~full | pop_ok);
    wr_n    = wr_q;
    rd_n    = rd_q;
    if (push_ok) wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (pop_ok)  rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    case ({push_ok, pop_ok})
      2'b10:   cnt_n = cnt_q + CW'(1);
      2'b01:   cnt_n = cnt_q - CW'(1);
      default: cnt_n = cnt_q;
    endcase
    if (push & ~push_ok) ovf_n = 1'b1;
    else if (ovf_clr)    ovf_n = 1'b0;
    else                 ovf_n = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign valid = ~empty;
  assign ovf   = ovf_q;

  // R6: occupancy never exceeds the queue depth
  assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R6: popping an empty queue leaves it empty
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && pop && !push) |=> !valid);
  // R7: a dropped event raises the flag
  assert_drop_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ovf);
  // R7: the flag holds until cleared
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/evt_capture_unit.sv
module evt_capture_unit
  import evt_pkg::*;
#(
  parameter int NPINS    = 4,
  parameter int NSTAGE   = 2,
  parameter int TS_W     = 32,
  parameter int WID_W    = 8,
  parameter int TMO_W    = 16,
  parameter int QDEPTH   = 8,
  parameter int SYNC_LAT = 2,
  localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int STG_W = (NSTAGE > 1) ? $clog2(NSTAGE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TS_W-1:0]         time_in,
  input  logic [NPINS-1:0]        pins_in,
  input  logic [NSTAGE*SEL_W-1:0] cfg_sel,
  input  logic [NSTAGE-1:0]       cfg_mode,
  input  logic [NSTAGE-1:0]       cfg_pol,
  input  logic [NSTAGE*WID_W-1:0] cfg_wmin,
  input  logic [NSTAGE*WID_W-1:0] cfg_wmax,
  input  logic [STG_W-1:0]        cfg_last,
  input  logic [TMO_W-1:0]        cfg_timeout,
  input  logic                    rd_pop,
  input  logic                    ovf_clr,
  output logic [TS_W-1:0]         rd_data,
  output logic                    rd_valid,
  output logic                    ovf_flag
);
  logic [NPINS-1:0]  lvl, lvl_d;
  logic [NSTAGE-1:0] hits;
  logic [STG_W-1:0]  stg_q, stg_n;
  logic [TMO_W-1:0]  tcnt_q, tcnt_n;
  logic              hit_cur, is_last, fire;
  logic [TS_W-1:0]   stamp;

  evt_pin_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .lvl(lvl), .lvl_d(lvl_d)
  );

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    evt_stage_det #(.NPINS(NPINS), .WID_W(WID_W)) u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl),
      .lvl_d(lvl_d),
      .sel  (cfg_sel[g*SEL_W +: SEL_W]),
      .mode (det_mode_e'(cfg_mode[g])),
      .pol  (cfg_pol[g]),
      .wmin (cfg_wmin[g*WID_W +: WID_W]),
      .wmax (cfg_wmax[g*WID_W +: WID_W]),
      .hit  (hits[g])
    );
  end

  always_comb begin
    hit_cur = 1'b0;
    for (int k = 0; k < NSTAGE; k++) begin
      if (stg_q == STG_W'(k)) hit_cur = hits[k];
    end
    is_last = (stg_q >= cfg_last) || (stg_q == STG_W'(NSTAGE - 1));
    fire    = hit_cur & is_last;
    stg_n   = stg_q;
    tcnt_n  = tcnt_q;
    if (hit_cur) begin
      stg_n  = is_last ? '0 : stg_q + STG_W'(1);
      tcnt_n = '0;
    end else if (stg_q != '0) begin
      if (tcnt_q >= cfg_timeout) begin
        stg_n  = '0;
        tcnt_n = '0;
      end else begin
        tcnt_n = tcnt_q + TMO_W'(1);
      end
    end
    stamp = time_in - TS_W'(SYNC_LAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      tcnt_q <= '0;
    end else begin
      stg_q  <= stg_n;
      tcnt_q <= tcnt_n;
    end
  end

  evt_ts_fifo #(.DEPTH(QDEPTH), .W(TS_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fire), .din(stamp), .pop(rd_pop),
    .ovf_clr(ovf_clr), .dout(rd_data), .valid(rd_valid), .ovf(ovf_flag)
  );

  // R3: a fired event into an empty queue is visible on the next cycle
  assert_push_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rd_valid) |=> rd_valid);
  // R8: a one-stage chain never leaves stage zero
  assert_single_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_q == '0 && cfg_last == '0) |=> (stg_q == '0));
  // R9: the wait counter of an armed stage stays within the timeout
  assert_tmo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_q != '0 && $stable(cfg_timeout)) |-> (tcnt_q <= cfg_timeout));
endmodule

// File: tb/evt_capture_unit_bench.sv
`timescale 1ns/1ps
module evt_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tnow = '0;
  logic [3:0]  pins = '0;
  logic [3:0]  cfg_sel = '0;
  logic [1:0]  cfg_mode = '0, cfg_pol = 2'b11;
  logic [15:0] cfg_wmin = '0, cfg_wmax = '0;
  logic        cfg_last = 1'b0;
  logic [15:0] cfg_timeout = 16'd10;
  logic        rd_pop = 1'b0, ovf_clr = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid, ovf_flag;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [31:0] mq[$];
  bit exp_ovf = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tnow <= tnow + 32'd1;

  evt_capture_unit u_evt_capture_unit (
    .clk(clk), .rst_n(rst_n), .time_in(tnow), .pins_in(pins),
    .cfg_sel(cfg_sel), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
    .cfg_wmin(cfg_wmin), .cfg_wmax(cfg_wmax), .cfg_last(cfg_last),
    .cfg_timeout(cfg_timeout), .rd_pop(rd_pop), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .rd_valid(rd_valid), .ovf_flag(ovf_flag)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<60000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void model_push(logic [31:0] t);
    if (mq.size() < 8) mq.push_back(t);
    else exp_ovf = 1;
  endfunction

  task automatic drive(int idx, bit v, bit evt);
    pins[idx] = v;
    if (evt) model_push(tnow);
  endtask

  task automatic pop_check(string req);
    logic [31:0] e;
    e = mq.pop_front();
    chk(req, "rd_valid", rd_valid, 1);
    chk(req, "rd_data", rd_data, e);
    rd_pop = 1'b1;
    cyc(1);
    rd_pop = 1'b0;
  endtask

  task automatic drain(string req);
    cyc(4);
    while (mq.size() > 0) pop_check(req);
    chk(req, "empty after drain", rd_valid, 0);
  endtask

  task automatic pulse(int idx, int w, bit pol, bit accept);
    drive(idx, pol, 0);
    cyc(w);
    drive(idx, !pol, accept);
    cyc(4);
  endtask

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1: reset state
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "ovf_flag", ovf_flag, 0);

    // R3: exact latency and stamp of one rising edge
    begin
      logic [31:0] t0;
      t0 = tnow;
      pins[0] = 1'b1;
      cyc(2);
      chk("R3", "not yet visible after 2 edges", rd_valid, 0);
      cyc(1);
      chk("R3", "visible after 3 edges", rd_valid, 1);
      chk("R3", "stamp", rd_data, t0);
      rd_pop = 1'b1; cyc(1); rd_pop = 1'b0;
      drive(0, 0, 0);
      cyc(4);
      chk("R2", "falling edge ignored when rising selected", rd_valid, 0);
    end

    // R2: falling polarity
    cfg_pol = 2'b10;
    drive(0, 1, 0); cyc(3);
    drive(0, 0, 1); cyc(3);
    drive(0, 1, 0); cyc(2);
    drive(0, 0, 1);
    drain("R2");

    // R5: pin select, other pins ignored
    cfg_pol = 2'b11;
    cfg_sel = 4'b0010;
    drive(1, 1, 0); drive(0, 1, 0); drive(3, 1, 0); cyc(3);
    drive(1, 0, 0); drive(0, 0, 0); drive(3, 0, 0); cyc(4);
    chk("R5", "unselected pins ignored", rd_valid, 0);
    drive(2, 1, 1); cyc(2); drive(2, 0, 0);
    drain("R5");

    // random edge bursts (R2, R3, R5, R6)
    for (int b = 0; b < 12; b++) begin
      int sel, nt, noise;
      bit pol;
      pol = 1'($urandom % 2);
      sel = int'($urandom % 4);
      noise = (sel + 1 + int'($urandom % 3)) % 4;
      cfg_pol = {1'b1, pol};
      cfg_sel = {2'b00, 2'(sel)};
      cyc(1);
      nt = 2 + int'($urandom % 12);
      for (int i = 0; i < nt; i++) begin
        bit nv;
        cyc(1 + int'($urandom % 4));
        nv = !pins[sel];
        drive(sel, nv, nv == pol);
        if ($urandom % 2 == 1) pins[noise] = !pins[noise];
      end
      cyc(2);
      if (pins[sel]) drive(sel, 0, pol == 0);
      pins[noise] = 1'b0;
      drain("R6 random burst");
    end

    // R4: pulse width window 3..5, high active
    cfg_sel = '0;
    cfg_pol = 2'b11;
    cfg_mode = 2'b01;
    cfg_wmin = 16'h0003;
    cfg_wmax = 16'h0005;
    cyc(2);
    pulse(0, 2, 1, 0);
    chk("R4", "short pulse rejected", rd_valid, 0);
    pulse(0, 6, 1, 0);
    chk("R4", "long pulse rejected", rd_valid, 0);
    pulse(0, 3, 1, 1);
    pulse(0, 5, 1, 1);
    drain("R4 boundaries");
    for (int i = 0; i < 10; i++) begin
      int w;
      w = 1 + int'($urandom % 8);
      pulse(0, w, 1, (w >= 3) && (w <= 5));
    end
    drain("R4 random widths");
    // R4: low-active pulse
    cfg_pol = 2'b10;
    drive(0, 1, 0); cyc(4);
    pulse(0, 4, 0, 1);
    pulse(0, 7, 0, 0);
    drain("R4 low active");
    drive(0, 0, 0); cyc(4);

    // R7: overflow, then R6 order and pop on empty
    cfg_mode = 2'b00;
    cfg_pol = 2'b11;
    cyc(4);
    chk("R7", "no events before overflow test", rd_valid, 0);
    for (int i = 0; i < 10; i++) begin
      drive(0, 1, 1); cyc(2);
      drive(0, 0, 0); cyc(2);
    end
    cyc(4);
    chk("R7", "ovf_flag set on drop", ovf_flag, 1);
    cyc(3);
    chk("R7", "ovf_flag sticky", ovf_flag, 1);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    chk("R7", "ovf_flag cleared", ovf_flag, 0);
    drain("R6 order after overflow");
    rd_pop = 1'b1; cyc(1); rd_pop = 1'b0;
    chk("R6", "pop on empty stays empty", rd_valid, 0);
    drive(0, 1, 1); cyc(2); drive(0, 0, 0);
    drain("R6 after empty pop");
    exp_ovf = 0;

    // R8 / R9: two-stage chain, pin0 rise then pin1 rise
    cfg_sel = 4'b0100;
    cfg_last = 1'b1;
    cfg_timeout = 16'd10;
    cyc(2);
    drive(1, 1, 0); cyc(4); drive(1, 0, 0); cyc(4);
    chk("R8", "second stage alone queues nothing", rd_valid, 0);
    drive(0, 1, 0); cyc(4);
    drive(1, 1, 1); cyc(4);
    drive(0, 0, 0); drive(1, 0, 0);
    drain("R8 chain event");
    drive(0, 1, 0); cyc(30);
    drive(1, 1, 0); cyc(5);
    chk("R9", "late second stage queues nothing", rd_valid, 0);
    drive(0, 0, 0); drive(1, 0, 0); cyc(4);
    drive(0, 1, 0); cyc(6);
    drive(1, 1, 1); cyc(2);
    drive(0, 0, 0); drive(1, 0, 0);
    drain("R9 chain recovers after timeout");
    chk("R7", "no overflow during chain tests", ovf_flag, 0);

    summary();
    $finish;
  end
endmodule